// File: doc/BRIEF.md
# VGA Colour Test-Pattern Generator

This block produces a 640x480, 60 Hz VGA raster from a 50 MHz system clock. It makes a pixel-rate enable that is high on every second clock. Two scan counters advance on that enable: a horizontal counter and a vertical counter. The block decodes active-low horizontal and vertical sync from the counters. It also draws one of four procedural test images from the counters alone, so no pixel memory is needed. Each colour channel is one bit wide, which gives eight colours.

A two-bit switch input chooses the image. The choices are vertical colour bars, horizontal colour bars, a colour checkerboard and the inverted checkerboard. The switch bits pass through a two-flop synchronizer. They are loaded into a pattern state machine only when the raster wraps back to its first pixel, so a frame never changes image partway through. The state machine has four states: `PAT_VBAR`, `PAT_HBAR`, `PAT_CHECK` and `PAT_CHECK_INV`. Its only transition is "load at frame wrap": on that tick the next state is the synchronized switch code, 00, 01, 10 or 11 in that state order. On every other cycle the state holds.

All timing boundaries and the bar sizes are parameters. The defaults give the standard 800x525 scan.

Top module: `vga_testpattern_gen`

## Requirements
- R1: After the synchronous reset is released, the pixel enable is high on every second clock. The scan position therefore advances by one pixel every two clocks, starting with the second clock edge after release.
- R2: The horizontal count runs 0 to 799 and then returns to 0, so one line takes 1600 clocks.
- R3: `hsync` is 0 while the horizontal count is 95 or less, and 1 otherwise.
- R4: The vertical count advances only on the pixel step where the horizontal count wraps. It runs 0 to 524 and then returns to 0.
- R5: `vsync` is 0 while the vertical count is 1 or less, and 1 otherwise.
- R6: A pixel is visible when the horizontal count is in 144..783 and the vertical count is in 35..514. Outside that window `rgb` is 000. Inside it, `rgb[2]` is red, `rgb[1]` is green and `rgb[0]` is blue, and colour index n drives `rgb` = n. The visible offsets are x = h - 144 and y = v - 35.
- R7: Switch code 00 gives eight vertical bars with colour index x/80.
- R8: Switch code 01 gives eight horizontal bars with colour index y/60.
- R9: Switch code 10 gives a checkerboard with index (x/80) XOR (y/60). Code 11 gives the bitwise inverse of that index.
- R10: The switch code takes effect only at the pixel step where the raster wraps from (799,524) to (0,0). A change made mid-frame leaves the rest of that frame unchanged. The frame that starts at reset always uses code 00.
- R11: While reset is held, both counters stay at 0, so `hsync` = 0, `vsync` = 0 and `rgb` = 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 2 | Test-image select code |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| rgb | output | 3 | One-bit red, green and blue |

## Verification
The sync and colour outputs are combinational decodes of the registered counters. They therefore change on the same clock edge as the counter step, at edges 2, 4, 6 and so on after reset release. The bench keeps a count of edges since release, derives the scan position as half of that count, and compares every output on the falling edge after each rising edge. A switch change must pass two synchronizer flops and then wait for the frame-wrap step, so the bench changes the switches mid-frame. It expects the old image until the wrap and the new image in the whole following frame. A second instance with a small raster keeps frame-level checks short.

// File: rtl/vga_tp_pkg.sv
package vga_tp_pkg;
    typedef enum logic [1:0] {
        PAT_VBAR      = 2'b00,
        PAT_HBAR      = 2'b01,
        PAT_CHECK     = 2'b10,
        PAT_CHECK_INV = 2'b11
    } pat_e;

    localparam int COLOR_W = 3;
endpackage

// File: rtl/vga_pix_tick.sv
module vga_pix_tick (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= ~tick_q;
    end

    assign tick = tick_q;

    // R1
    tick_fall_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    // R1
    tick_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> tick);
endmodule

// File: rtl/vga_scan_counter.sv
module vga_scan_counter #(
    parameter int TOTAL = 800,
    localparam int W    = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == W'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (adv)  cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R2 R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= W'(TOTAL - 1));
    // R2 R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (cnt_q == '0));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));
endmodule

// File: rtl/vga_pattern_sel.sv
module vga_pattern_sel
    import vga_tp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         sw,
    input  logic               frame_start,
    input  logic [COLOR_W-1:0] col_idx,
    input  logic [COLOR_W-1:0] row_idx,
    output logic [COLOR_W-1:0] color
);
    logic [1:0] sw_s1, sw_s2;
    pat_e       state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_s1 <= 2'b00;
            sw_s2 <= 2'b00;
        end else begin
            sw_s1 <= sw;
            sw_s2 <= sw_s1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            unique case (sw_s2)
                2'b00: state_d = PAT_VBAR;
                2'b01: state_d = PAT_HBAR;
                2'b10: state_d = PAT_CHECK;
                2'b11: state_d = PAT_CHECK_INV;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PAT_VBAR;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PAT_VBAR:      color = col_idx;
            PAT_HBAR:      color = row_idx;
            PAT_CHECK:     color = col_idx ^ row_idx;
            PAT_CHECK_INV: color = ~(col_idx ^ row_idx);
        endcase
    end

    // R10
    pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(state_q));
endmodule

// File: rtl/vga_testpattern_gen.sv
module vga_testpattern_gen
    import vga_tp_pkg::*;
#(
    parameter int H_TOTAL     = 800,
    parameter int H_SYNC_END  = 95,
    parameter int H_ACT_START = 144,
    parameter int H_ACT_END   = 783,
    parameter int V_TOTAL     = 525,
    parameter int V_SYNC_END  = 1,
    parameter int V_ACT_START = 35,
    parameter int V_ACT_END   = 514,
    parameter int BAR_W       = 80,
    parameter int BAR_H       = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sw,
    output logic       hsync,
    output logic       vsync,
    output logic [2:0] rgb
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);

    logic               tick;
    logic [HW-1:0]      h_cnt;
    logic [VW-1:0]      v_cnt;
    logic               h_last, v_last;
    logic               frame_start;
    logic               h_vis, v_vis;
    logic [HW-1:0]      x_off;
    logic [VW-1:0]      y_off;
    logic [COLOR_W-1:0] col_idx, row_idx, color;

    vga_pix_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    vga_scan_counter #(.TOTAL(H_TOTAL)) u_hcnt (
        .clk  (clk),
        .rst  (rst),
        .adv  (tick),
        .cnt  (h_cnt),
        .last (h_last)
    );

    vga_scan_counter #(.TOTAL(V_TOTAL)) u_vcnt (
        .clk  (clk),
        .rst  (rst),
        .adv  (tick && h_last),
        .cnt  (v_cnt),
        .last (v_last)
    );

    assign frame_start = tick && h_last && v_last;

    always_comb begin
        h_vis   = (h_cnt >= HW'(H_ACT_START)) && (h_cnt <= HW'(H_ACT_END));
        v_vis   = (v_cnt >= VW'(V_ACT_START)) && (v_cnt <= VW'(V_ACT_END));
        x_off   = h_cnt - HW'(H_ACT_START);
        y_off   = v_cnt - VW'(V_ACT_START);
        col_idx = COLOR_W'(x_off / HW'(BAR_W));
        row_idx = COLOR_W'(y_off / VW'(BAR_H));
    end

    vga_pattern_sel u_pat (
        .clk         (clk),
        .rst         (rst),
        .sw          (sw),
        .frame_start (frame_start),
        .col_idx     (col_idx),
        .row_idx     (row_idx),
        .color       (color)
    );

    always_comb begin
        hsync = (h_cnt > HW'(H_SYNC_END));
        vsync = (v_cnt > VW'(V_SYNC_END));
        rgb   = (h_vis && v_vis) ? color : '0;
    end

    // R6
    blank_hsync_chk: assert property (@(posedge clk) disable iff (rst)
        !hsync |-> (rgb == 3'b000));
    // R6
    blank_vsync_chk: assert property (@(posedge clk) disable iff (rst)
        !vsync |-> (rgb == 3'b000));
endmodule

// File: tb/sim_vga_testpattern_gen.sv
module sim_vga_testpattern_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sw0 = 2'b00;
    logic [1:0] sw1 = 2'b00;
    logic       hs0, vs0, hs1, vs1;
    logic [2:0] rgb0, rgb1;
    int         n = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    localparam int F1 = 2 * 40 * 20;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    vga_testpattern_gen u0 (
        .clk(clk), .rst(rst), .sw(sw0),
        .hsync(hs0), .vsync(vs0), .rgb(rgb0)
    );

    vga_testpattern_gen #(
        .H_TOTAL(40), .H_SYNC_END(3), .H_ACT_START(8), .H_ACT_END(23),
        .V_TOTAL(20), .V_SYNC_END(1), .V_ACT_START(4), .V_ACT_END(11),
        .BAR_W(2), .BAR_H(1)
    ) u1 (
        .clk(clk), .rst(rst), .sw(sw1),
        .hsync(hs1), .vsync(vs1), .rgb(rgb1)
    );

    function automatic logic [4:0] model(int k, int ht, int hse, int has, int hae,
                                         int vt, int vse, int vas, int vae,
                                         int bw, int bh, int pat);
        int p, h, v, bx, by, idx;
        bit vis;
        p   = k / 2;
        h   = p % ht;
        v   = (p / ht) % vt;
        vis = (h >= has) && (h <= hae) && (v >= vas) && (v <= vae);
        bx  = vis ? (h - has) / bw : 0;
        by  = vis ? (v - vas) / bh : 0;
        case (pat)
            0:       idx = bx;
            1:       idx = by;
            2:       idx = bx ^ by;
            default: idx = ~(bx ^ by);
        endcase
        return {h > hse, v > vse, vis ? 3'(idx) : 3'b000};
    endfunction

    task automatic check_span(input bit big, input int ncyc, input int pat, input string tag);
        bit bad = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            logic [4:0] got, exp;
            @(negedge clk);
            if (big) begin
                got = {hs0, vs0, rgb0};
                exp = model(n, 800, 95, 144, 783, 525, 1, 35, 514, 80, 60, pat);
            end else begin
                got = {hs1, vs1, rgb1};
                exp = model(n, 40, 3, 8, 23, 20, 1, 4, 11, 2, 1, pat);
            end
            if (got !== exp && !bad) begin
                bad = 1'b1;
                $display("FAIL %s at edge %0d: actual %b expected %b", tag, n, got, exp);
            end
        end
        checks++;
        if (bad) errors++;
    endtask

    task automatic wait_frame1(input int ofs);
        do @(negedge clk); while ((n % F1) != ofs);
    endtask

    task automatic apply_sw1(input logic [1:0] v);
        wait_frame1(800);
        sw1 = v;
        wait_frame1(F1 - 1);
    endtask

    task automatic check_outputs_idle(input string tag);
        checks++;
        if ({hs0, vs0, rgb0} !== 5'b0) begin
            errors++;
            $display("FAIL %s big: actual %b expected 00000", tag, {hs0, vs0, rgb0});
        end
        checks++;
        if ({hs1, vs1, rgb1} !== 5'b0) begin
            errors++;
            $display("FAIL %s small: actual %b expected 00000", tag, {hs1, vs1, rgb1});
        end
    endtask

    task automatic t_reset_state();
        repeat (4) @(negedge clk);
        check_outputs_idle("R11 reset state");
    endtask

    task automatic t_line_timing();
        @(negedge clk);
        rst = 1'b0;
        check_span(1'b1, 3 * 1600, 0, "R1 R2 R3 R5 line timing");
    endtask

    task automatic t_visible_vbars();
        check_span(1'b1, 65200, 0, "R4 R6 R7 visible window vertical bars");
    endtask

    task automatic t_small_patterns();
        apply_sw1(2'b01);
        check_span(1'b0, F1 - 1, 1, "R8 horizontal bars");
        apply_sw1(2'b10);
        check_span(1'b0, F1 - 1, 2, "R9 checkerboard");
        apply_sw1(2'b11);
        check_span(1'b0, F1 - 1, 3, "R9 inverse checkerboard");
    endtask

    task automatic t_midframe_change();
        wait_frame1(F1 - 1);
        check_span(1'b0, 700, 3, "R10 before mid-frame change");
        sw1 = 2'b01;
        check_span(1'b0, F1 - 1 - 700, 3, "R10 mid-frame change ignored");
        check_span(1'b0, F1, 1, "R10 new code at next frame");
    endtask

    task automatic t_reset_midrun();
        @(negedge clk);
        rst = 1'b1;
        sw1 = 2'b01;
        repeat (6) @(negedge clk);
        check_outputs_idle("R11 reset mid-run");
        rst = 1'b0;
        check_span(1'b0, F1 - 1, 0, "R10 R11 first frame after reset");
        check_span(1'b0, F1, 1, "R10 second frame after reset");
    endtask

    initial begin
        t_reset_state();
        t_line_timing();
        t_visible_vbars();
        t_small_patterns();
        t_midframe_change();
        t_reset_midrun();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete in time");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule